// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a single-shot watchdog timer that counts strobes of a 16 Hz clock enable. Software programs one 8-bit control register with a timeout and with a choice of action on expiry. The timeout is a 5-bit multiplier times a power of four picked by a 2-bit resolution field, in sixteenths of a second. Any access to the control register, whether a write or a plain read, services the watchdog. It restarts the countdown and clears the expiry flag.

On expiry the block sets a sticky flag in a read-only flags register. The steering bit then selects one of two actions. When it is set, the block raises a reset request, clears the control register and clears bit 6 of an auxiliary date/century register. When it is clear, the block pulses an interrupt instead. A register-select input picks among the control, flags and auxiliary registers. Address decoding beyond that select is left to the surrounding fabric.

The sequencer has three states:
- `WD_IDLE`: disarmed or spent.
- `WD_ARMED`: counting.
- `WD_FIRE`: a one-cycle expiry state that drives the output pulse.

Transitions:
- IDLE→ARMED on a service with a nonzero multiplier.
- ARMED→ARMED on a reload.
- ARMED→IDLE on a service with a zero multiplier.
- ARMED→FIRE on the strobe that ends the count.
- FIRE→ARMED on a service with a nonzero multiplier in the fire cycle.
- FIRE→IDLE otherwise.

Top module: `wdog_unit`

## Requirements
- R1: After reset the control, flags and auxiliary registers read 0x00, and both `wd_irq` and `wd_reset_req` are low.
- R2: The control register holds the resolution in bits 1:0 and the multiplier in bits 6:2. After a service that loads a nonzero multiplier M and resolution R, the watchdog expires on the M·4^R-th `tick` strobe and on no earlier strobe.
- R3: A multiplier of zero disables the watchdog whatever the resolution and steering bits hold: no expiry occurs.
- R4: A write to the control register loads the new value, reloads the countdown from it and clears the expiry flag. A write in the same cycle as the final strobe wins, so no expiry occurs and the new count starts.
- R5: A read of the control register (`rd_en` with select 0) reloads the countdown from the current value and clears the expiry flag.
- R6: Expiry sets bit 7 of the flags register (select 1), and all other bits read 0. Writes to the flags register are ignored.
- R7: With bit 7 of the control register set at expiry, `wd_reset_req` pulses high for exactly one cycle. The control register becomes 0x00, and bit 6 of the auxiliary register is cleared while its other bits are kept.
- R8: With bit 7 of the control register clear at expiry, `wd_irq` pulses high for exactly one cycle. The control register keeps its value and the auxiliary register is untouched.
- R9: After an expiry no further pulse occurs, however many strobes follow, until the watchdog is serviced again.
- R10: Select 2 is a plain read/write auxiliary register. Select 3 reads 0x00. `rdata` shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 16 Hz clock-enable strobe, one cycle wide |
| reg_sel | input | 2 | Register select: 0 control, 1 flags, 2 auxiliary, 3 none |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| wd_irq | output | 1 | One-cycle interrupt pulse on interrupt-steered expiry |
| wd_reset_req | output | 1 | One-cycle reset request on reset-steered expiry |

## Verification
The bound checker watches the following on every cycle:
- The two output pulses never overlap and last one cycle each.
- A pulse only ever follows a strobe and always comes with the expiry flag set.
- A reset-steered pulse always comes with a cleared control register.
- Any control write or read leaves the flag clear on the next cycle.

The exact tick count to expiry for each multiplier and resolution pair needs the bench's scenarios. So do the following:
- the silence of a zero multiplier;
- the one-shot behaviour;
- the reload by a plain read;
- the write that collides with the final strobe;
- the selective clearing of the auxiliary bit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int REG_W    = 8;
    localparam int MULT_W   = 5;
    localparam int RES_W    = 2;
    localparam int CNT_W    = MULT_W + 2 * ((1 << RES_W) - 1);
    localparam int STEER_BIT = 7;
    localparam int FLAG_BIT  = 7;
    localparam int AUX_CLR_BIT = 6;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_FLAGS = 2'd1,
        SEL_AUX   = 2'd2,
        SEL_NONE  = 2'd3
    } wd_sel_e;
endpackage

// File: rtl/wdog_span.sv
module wdog_span #(
    parameter int REG_W  = 8,
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [REG_W-1:0] ctrl,
    output logic [CNT_W-1:0] span,
    output logic             live
);
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;

    assign mult = ctrl[RES_W +: MULT_W];
    assign res  = ctrl[RES_W-1:0];
    assign live = |mult;
    // multiplier scaled by four to the power of the resolution
    assign span = CNT_W'(mult) << {res, 1'b0};
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec && count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign last = (count_q == CNT_W'(1));
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      svc,
    input  logic      span_live,
    input  logic      tick,
    input  logic      last,
    input  logic      steer,
    output wd_state_e state,
    output logic      expire,
    output logic      irq_pulse,
    output logic      rst_pulse
);
    wd_state_e state_q, state_d;
    logic      fire_rst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= WD_IDLE;
            fire_rst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (expire) fire_rst_q <= steer;
        end
    end

    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        unique case (state_q)
            WD_IDLE: begin
                if (svc && span_live) state_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (svc) begin
                    state_d = span_live ? WD_ARMED : WD_IDLE;
                end else if (tick && last) begin
                    expire  = 1'b1;
                    state_d = WD_FIRE;
                end
            end
            WD_FIRE: begin
                state_d = (svc && span_live) ? WD_ARMED : WD_IDLE;
            end
            default: state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        irq_pulse = 1'b0;
        rst_pulse = 1'b0;
        unique case (state_q)
            WD_FIRE: begin
                irq_pulse = !fire_rst_q;
                rst_pulse = fire_rst_q;
            end
            WD_IDLE, WD_ARMED: ;
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             expire,
    output logic [REG_W-1:0] ctrl_q,
    output logic             flag_q,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] aux_q, aux_d;
    logic             ctrl_hit;

    assign ctrl_hit = (sel == SEL_CTRL);

    always_comb begin
        aux_d = aux_q;
        if (wr_en && sel == SEL_AUX) aux_d = wdata;
        if (expire && ctrl_q[STEER_BIT]) aux_d[AUX_CLR_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
            aux_q  <= '0;
        end else begin
            aux_q <= aux_d;
            if (ctrl_hit && wr_en) begin
                ctrl_q <= wdata;
            end else if (expire && ctrl_q[STEER_BIT]) begin
                ctrl_q <= '0;
            end
            if (ctrl_hit && (wr_en || rd_en)) begin
                flag_q <= 1'b0;
            end else if (expire) begin
                flag_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL:  rdata = ctrl_q;
            SEL_FLAGS: rdata[FLAG_BIT] = flag_q;
            SEL_AUX:   rdata = aux_q;
            SEL_NONE:  rdata = '0;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_unit.sv
module wdog_unit
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             wd_irq,
    output logic             wd_reset_req
);
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] load_src;
    logic [CNT_W-1:0] span;
    logic             span_live;
    logic             wd_flag;
    logic             svc;
    logic             last;
    logic             expire;
    wd_state_e        state;

    assign svc      = (reg_sel == SEL_CTRL) && (wr_en || rd_en);
    assign load_src = wr_en ? wdata : ctrl_q;

    wdog_span #(
        .REG_W (REG_W),
        .MULT_W(MULT_W),
        .RES_W (RES_W),
        .CNT_W (CNT_W)
    ) u_span (
        .ctrl(load_src),
        .span(span),
        .live(span_live)
    );

    wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (svc),
        .load_val(span),
        .dec     (tick && state == WD_ARMED),
        .last    (last)
    );

    wdog_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc      (svc),
        .span_live(span_live),
        .tick     (tick),
        .last     (last),
        .steer    (ctrl_q[STEER_BIT]),
        .state    (state),
        .expire   (expire),
        .irq_pulse(wd_irq),
        .rst_pulse(wd_reset_req)
    );

    wdog_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (reg_sel),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .expire(expire),
        .ctrl_q(ctrl_q),
        .flag_q(wd_flag),
        .rdata (rdata)
    );
endmodule

// File: rtl/wdog_props.sv
module wdog_props (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [1:0] reg_sel,
    input logic       wr_en,
    input logic       rd_en,
    input logic       irq,
    input logic       rst_req,
    input logic       flag,
    input logic [7:0] ctrl
);
    p_pulses_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req));

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_rst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_pulse_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || rst_req) |-> $past(tick));

    p_flag_on_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || rst_req) |-> flag);

    p_rst_clears_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (ctrl == 8'h00));

    p_write_clears_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd0) |=> !flag);

    p_read_clears_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == 2'd0) |=> !flag);
endmodule

bind wdog_unit wdog_props u_props (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .reg_sel(reg_sel),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .irq    (wd_irq),
    .rst_req(wd_reset_req),
    .flag   (wd_flag),
    .ctrl   (ctrl_q)
);

// File: tb/sim_wdog_unit.sv
module sim_wdog_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] reg_sel = 2'd3;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       wd_irq;
    logic       wd_reset_req;

    int n_tests = 0;
    int n_fail  = 0;
    int irq_seen = 0;
    int rst_seen = 0;

    always #4 clk = ~clk;

    wdog_unit u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_sel(reg_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .wd_irq(wd_irq), .wd_reset_req(wd_reset_req)
    );

    always @(negedge clk) begin
        if (wd_irq) irq_seen++;
        if (wd_reset_req) rst_seen++;
    end

    // {control value, ticks to expiry, reset-steered}
    localparam logic [31:0] VEC [0:5] = '{
        {8'h05, 16'd4,   8'd0},
        {8'h0C, 16'd3,   8'd0},
        {8'h86, 16'd16,  8'd1},
        {8'h7E, 16'd496, 8'd0},
        {8'h8B, 16'd128, 8'd1},
        {8'h04, 16'd1,   8'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        #1200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int i0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        do_rd(2'd1, v); chk("R1 flags", v, 8'h00);
        do_rd(2'd2, v); chk("R1 aux", v, 8'h00);
        chk("R1 outputs", {wd_irq, wd_reset_req}, 0);

        // R10 select map
        do_wr(2'd2, 8'h5A); do_rd(2'd2, v); chk("R10 aux rw", v, 8'h5A);
        do_rd(2'd3, v); chk("R10 sel3", v, 8'h00);

        // table: R2 timeout, R7/R8 steering, R6 flag, R9 one-shot
        for (int k = 0; k < 6; k++) begin
            logic [7:0] c;
            int n;
            logic r;
            c = VEC[k][31:24]; n = int'(VEC[k][23:8]); r = VEC[k][0];
            do_wr(2'd2, 8'hFF);
            do_wr(2'd0, c);
            i0 = irq_seen; r0 = rst_seen;
            ticks(n - 1);
            chk("R2 no early expiry", irq_seen + rst_seen, i0 + r0);
            do_rd(2'd1, v); chk("R2 flag before", v, 8'h00);
            ticks(1);
            chk("R8 irq at expiry", wd_irq, !r);
            chk("R7 reset at expiry", wd_reset_req, r);
            @(negedge clk);
            chk("R7 R8 single cycle", {wd_irq, wd_reset_req}, 0);
            do_rd(2'd1, v); chk("R6 flag set", v, 8'h80);
            do_rd(2'd2, v); chk("R7 aux bit6", v, r ? 8'hBF : 8'hFF);
            if (r) begin
                do_rd(2'd0, v); chk("R7 ctrl cleared", v, 8'h00);
            end else begin
                i0 = irq_seen;
                ticks(5);
                chk("R9 one-shot", irq_seen, i0);
                do_rd(2'd0, v); chk("R8 ctrl kept", v, c);
                do_rd(2'd1, v); chk("R5 read clears flag", v, 8'h00);
                do_wr(2'd0, 8'h00);
            end
        end

        // R3 zero multiplier disables
        i0 = irq_seen; r0 = rst_seen;
        do_wr(2'd0, 8'h03); ticks(300);
        do_wr(2'd0, 8'h80); ticks(50);
        chk("R3 disabled", irq_seen + rst_seen, i0 + r0);

        // R5 read reloads
        do_wr(2'd0, 8'h10);
        ticks(3);
        do_rd(2'd0, v);
        i0 = irq_seen;
        ticks(3);
        chk("R5 reload by read", irq_seen, i0);
        ticks(1);
        chk("R5 expiry after reload", wd_irq, 1);

        // R6 flags writes ignored, R4 write clears flag
        do_wr(2'd1, 8'h00); do_rd(2'd1, v); chk("R6 flags write ignored", v, 8'h80);
        do_wr(2'd1, 8'hFF); do_wr(2'd0, 8'h00);
        do_rd(2'd1, v); chk("R4 write clears flag", v, 8'h00);

        // R4 write colliding with final strobe
        do_wr(2'd0, 8'h04);
        i0 = irq_seen;
        @(negedge clk);
        tick = 1'b1; reg_sel = 2'd0; wdata = 8'h08; wr_en = 1'b1;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk("R4 write beats expiry", irq_seen + wd_irq, i0);
        ticks(1);
        chk("R4 new count runs", wd_irq, 0);
        ticks(1);
        chk("R4 expiry on new count", wd_irq, 1);

        // R1 reset mid-count
        do_wr(2'd0, 8'h84);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        r0 = rst_seen;
        ticks(4);
        chk("R1 reset disarms", rst_seen, r0);
        do_rd(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule